// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic unit of a small 8-bit accumulator-style processor datapath. It receives a 4-bit operation code and three data inputs: the accumulator value, a second register value, and the operand. The second register is used by compare and by register transfer. The operand is a memory byte, or whatever value the caller routes in for shift and count operations. The block also receives an incoming carry and the current flag bits. It computes the 8-bit result and a write-enable that tells the caller whether a register or memory location should take that result. It also computes the next N, V, Z and C flags.

The result, the write-enable and the next flags are combinational, so they are ready in the same cycle the operation is presented. The next flags are also captured into a status register when the caller pulses `go`. Flags that an operation does not own pass through from `flg_in` unchanged. Decimal arithmetic, decoding, addressing and memory access belong to the surrounding datapath.

Top module: `acc_alu`

## Requirements
- R1: Flag vectors are packed as bit 3 = N, bit 2 = V, bit 1 = Z, bit 0 = C. Flags that an operation does not update equal the corresponding bits of `flg_in`. For every operation that writes, N equals result bit 7 and Z is 1 exactly when the result is 0x00.
- R2: Codes 0, 1 and 2 give OR, AND and XOR of `a_in` with `m_in`. They assert `res_we` and update only N and Z.
- R3: Code 3 (add) forms the 9-bit sum a_in + m_in + c_in. The result is the low 8 bits. C is set when the sum is above 0xFF. V is set when a_in and m_in have the same sign and the result's sign differs from it.
- R4: Code 4 (subtract) forms 0x100 + a_in − m_in − c_in. The result is the low 8 bits. C is set when that total is 0xFF or less. V is set when a_in and the inverted m_in have the same sign and the result's sign differs from it.
- R5: Code 5 (compare) computes r_in − m_in without writing: `res_we` is 0. N and Z come from the 8-bit difference. C is set when r_in ≥ m_in. V is kept.
- R6: Code 6 (bit test) does not write. It sets Z when (a_in AND m_in) is zero and copies m_in bit 7 to N and m_in bit 6 to V. C is kept.
- R7: Codes 7 and 8 shift m_in left or right by one bit. A zero enters the vacated bit and the bit shifted out goes to C. N and Z are updated.
- R8: Codes 9 and 10 rotate m_in left or right by one bit through the carry. c_in enters the vacated bit and the bit shifted out goes to C.
- R9: Codes 11 and 12 increment or decrement m_in modulo 256 and update only N and Z.
- R10: Code 13 passes m_in (a load) and code 14 passes r_in (a register transfer) to the result, with a write and an N/Z update.
- R11: Code 15 does nothing: `res_we` is 0 and `flg_nxt` equals `flg_in`.
- R12: `flg_q` takes `flg_nxt` on a clock edge where `go` is 1 and holds its value when `go` is 0.
- R13: While reset is asserted (active low), `flg_q` is 0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Capture next flags into status register |
| op | input | 4 | Operation code |
| a_in | input | 8 | Accumulator value |
| r_in | input | 8 | Register for compare or transfer |
| m_in | input | 8 | Operand |
| c_in | input | 1 | Incoming carry |
| flg_in | input | 4 | Current flags {N,V,Z,C} |
| res | output | 8 | Result |
| res_we | output | 1 | Result should be written |
| flg_nxt | output | 4 | Next flags {N,V,Z,C} |
| flg_q | output | 4 | Registered flags |

## Verification
Every operation code is swept over the corner values 0x00, 0x7F, 0x80 and 0xFF for the accumulator, the second register and the operand, with carry-in 0 and 1. Add and subtract at these corners separate carry from overflow: 0x7F+0x00+1 overflows without carry, and 0xFF+0x80 carries with overflow. Compare and subtract on equal values separate the ≥ rule from the borrow rule. Two alternating `flg_in` patterns expose any flag that an operation alters but should keep, and alternating `go` shows whether the status register loads and holds correctly.

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [3:0]   op,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] r_in,
  input  logic [W-1:0] m_in,
  input  logic         c_in,
  input  logic [3:0]   flg_in,
  output logic [W-1:0] res,
  output logic         res_we,
  output logic [3:0]   flg_nxt,
  output logic [3:0]   flg_q
);
  localparam int MSB = W - 1;

  logic [W:0] add_t, sub_t, cmp_t;
  logic fn, fv, fz, fc;

  assign add_t = {1'b0, a_in} + {1'b0, m_in} + {{W{1'b0}}, c_in};
  assign sub_t = {1'b1, a_in} - {1'b0, m_in} - {{W{1'b0}}, c_in};
  assign cmp_t = {1'b0, r_in} - {1'b0, m_in};

  always_comb begin
    res    = '0;
    res_we = 1'b1;
    fn = flg_in[3];
    fv = flg_in[2];
    fz = flg_in[1];
    fc = flg_in[0];
    case (op)
      4'd0:  res = a_in | m_in;
      4'd1:  res = a_in & m_in;
      4'd2:  res = a_in ^ m_in;
      4'd3: begin
        res = add_t[MSB:0];
        fc  = add_t[W];
        fv  = (a_in[MSB] == m_in[MSB]) && (add_t[MSB] != a_in[MSB]);
      end
      4'd4: begin
        res = sub_t[MSB:0];
        fc  = ~sub_t[W];
        fv  = (a_in[MSB] != m_in[MSB]) && (sub_t[MSB] != a_in[MSB]);
      end
      4'd5: begin
        res_we = 1'b0;
        res    = cmp_t[MSB:0];
        fc     = ~cmp_t[W];
      end
      4'd6: begin
        res_we = 1'b0;
        res    = a_in & m_in;
      end
      4'd7: begin
        res = {m_in[MSB-1:0], 1'b0};
        fc  = m_in[MSB];
      end
      4'd8: begin
        res = {1'b0, m_in[MSB:1]};
        fc  = m_in[0];
      end
      4'd9: begin
        res = {m_in[MSB-1:0], c_in};
        fc  = m_in[MSB];
      end
      4'd10: begin
        res = {c_in, m_in[MSB:1]};
        fc  = m_in[0];
      end
      4'd11: res = m_in + 1'b1;
      4'd12: res = m_in - 1'b1;
      4'd13: res = m_in;
      4'd14: res = r_in;
      default: res_we = 1'b0;
    endcase
    if (op == 4'd6) begin
      fn = m_in[MSB];
      fv = m_in[MSB-1];
      fz = ~|res;
    end else if (op != 4'd15) begin
      fn = res[MSB];
      fz = (res == '0);
    end
  end

  assign flg_nxt = {fn, fv, fz, fc};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  flg_q <= 4'b0000;
    else if (go) flg_q <= flg_nxt;
  end

  // R12
  flg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> flg_q == $past(flg_nxt));

  // R12
  flg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> $stable(flg_q));

  // R1
  n_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> flg_nxt[3] == res[MSB]);

  // R1
  z_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> flg_nxt[1] == (res == '0));

  // R11
  idle_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd15) |-> (!res_we && flg_nxt == flg_in));

  // R5
  cmp_keep_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd5) |-> (!res_we && flg_nxt[2] == flg_in[2]));
endmodule

// File: tb/sim_acc_alu.sv
module sim_acc_alu;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, go = 1'b0, c_in = 1'b0;
  logic [3:0] op = '0, flg_in = '0;
  logic [7:0] a_in = '0, r_in = '0, m_in = '0;
  logic [7:0] res;
  logic res_we;
  logic [3:0] flg_nxt, flg_q;

  int n_chk = 0, n_bad = 0;

  acc_alu u0 (.clk, .rst_n, .go, .op, .a_in, .r_in, .m_in, .c_in, .flg_in,
              .res, .res_we, .flg_nxt, .flg_q);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic string tag(int o);
    case (o)
      0, 1, 2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7, 8: return "R7";
      9, 10: return "R8";
      11, 12: return "R9";
      13, 14: return "R10";
      default: return "R11";
    endcase
  endfunction

  // expected {we, res, flags}
  function automatic logic [12:0] model(int o, int a, int r, int m, int c, logic [3:0] fi);
    int t; int rs; logic we; logic n, v, z, cf;
    n = fi[3]; v = fi[2]; z = fi[1]; cf = fi[0]; we = 1; rs = 0;
    case (o)
      0: rs = a | m;
      1: rs = a & m;
      2: rs = a ^ m;
      3: begin t = a + m + c; rs = t % 256; cf = t > 255;
         v = (((a ^ rs) & (m ^ rs) & 128) != 0); end
      4: begin t = 256 + a - m - c; rs = t % 256; cf = t <= 255;
         v = (((a ^ m) & (a ^ rs) & 128) != 0); end
      5: begin we = 0; t = r - m; rs = (t + 256) % 256; cf = r >= m; end
      6: we = 0;
      7: begin cf = m >= 128; rs = (m * 2) % 256; end
      8: begin cf = m % 2; rs = m / 2; end
      9: begin cf = m >= 128; rs = (m * 2 + c) % 256; end
      10: begin cf = m % 2; rs = m / 2 + c * 128; end
      11: rs = (m + 1) % 256;
      12: rs = (m + 255) % 256;
      13: rs = m;
      14: rs = r;
      default: we = 0;
    endcase
    if (o == 6) begin n = m >= 128; v = (m / 64) % 2; z = (a & m) == 0; end
    else if (o != 15) begin n = rs >= 128; z = rs == 0; end
    return {we, rs[7:0], n, v, z, cf};
  endfunction

  task automatic check(string rq, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] corner [4];
    logic [3:0] held;
    logic [12:0] e;
    int k;
    corner[0] = 8'h00; corner[1] = 8'h7F; corner[2] = 8'h80; corner[3] = 8'hFF;
    repeat (3) @(negedge clk);
    // R13
    check("R13", "flg_q in reset", flg_q, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R13", "flg_q after reset", flg_q, 0);
    held = flg_q; k = 0;
    for (int o = 0; o < 16; o++)
      for (int ai = 0; ai < 4; ai++)
        for (int ri = 0; ri < 4; ri++)
          for (int mi = 0; mi < 4; mi++)
            for (int c = 0; c < 2; c++) begin
              op = 4'(o); a_in = corner[ai]; r_in = corner[ri]; m_in = corner[mi];
              c_in = c[0]; flg_in = k[0] ? 4'b1010 : 4'b0101;
              go = k[1];
              #1;
              e = model(o, a_in, r_in, m_in, c, flg_in);
              check(tag(o), "res_we", res_we, e[12]);
              if (e[12]) check(tag(o), "res", res, e[11:4]);
              check(tag(o), "flags", flg_nxt, e[3:0]);
              // R1: N and Z track a written result
              if (res_we) check("R1", "N/Z vs res", {flg_nxt[3], flg_nxt[1]},
                                {res[7], res == 8'h00});
              @(negedge clk);
              if (go) held = e[3:0];
              // R12
              check("R12", "flg_q", flg_q, held);
              k++;
            end
    go = 1'b0;
    op = 4'd3; a_in = 8'hFF; m_in = 8'h01; c_in = 1'b0; flg_in = 4'b0000;
    @(negedge clk);
    check("R12", "hold without go", flg_q, held);
    go = 1'b1;
    @(negedge clk);
    check("R12", "load add carry", flg_q, 4'b0011);
    rst_n = 1'b0;
    #1;
    check("R13", "async clear", flg_q, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule